// File: doc/BRIEF.md
# Split-Port Burst SRAM Core

This block is an on-chip memory that presents the interface of a separate-I/O, quad-data-rate burst SRAM. It has a read port and a write port. Each port has its own active-low select, and each has its own data path: `rdata` for reads and `wdata` for writes. The two ports share one address bus. A single beat clock `clk` runs at twice the command rate and stands for both edges of a complementary clock pair. Every four beats form a command frame. The first edge of the frame is the read-address slot and the third edge is the write-address slot. Each address names a group of four words. The group moves as a burst of one word per beat, so one burst fills a full frame on each port. Reads and writes may overlap freely.

Read data returns on `rdata` with `rvalid` marking the beats that carry data. The delay before the first word is chosen by `lat_long`: a short mode of two beats or a long mode of five beats (2.5 command cycles). The write beats of a burst are buffered and the group is committed to the array in one write when its last word arrives. A read that overlaps an uncommitted write to the same group is served by forwarding, so reads always see every write accepted before them. The host aligns itself with `rd_slot`, which is high in the beat before each read-address edge.

Top module: `split_burst_sram`

## Requirements
- R1: While `rst` is high and on the first edge after it falls, `rvalid` is low, `rdata` is zero and `rd_slot` is high. The first edge after reset is a read-address slot.
- R2: `rd_slot` is high for one beat in every four. `addr` and `rd_sel_n` are used only on the edge that follows a high `rd_slot` (slot 0). `addr` and `wr_sel_n` are used only two edges later (slot 2). On slots 1 and 3 the select and address inputs have no effect.
- R3: A write to group g takes word j (j = 0..3) from `wdata` on the edge 1+j beats after its address edge. A read of group g returns words 0,1,2,3 in that order on consecutive beats.
- R4: With `lat_long` low, word 0 of a read is on `rdata` after the edge two beats after the read-address edge.
- R5: With `lat_long` high, word 0 of a read is on `rdata` after the edge five beats after the read-address edge.
- R6: `rvalid` is high on exactly the four beats of each read burst and low on every other beat.
- R7: A read slot with `rd_sel_n` high produces no output beats. A write slot with `wr_sel_n` high leaves the array unchanged, and the `wdata` beats that follow it are ignored.
- R8: A read returns the newest data of every write whose address edge came before the read-address edge. This includes a write whose beats are still arriving. A write accepted at the write slot that follows the read does not affect that read.
- R9: A read issued in every frame yields a continuous `rvalid` with no idle beat between bursts.
- R10: `rdata` is zero on every beat where `rvalid` is low.
- R11: Reads and writes to any mix of groups, issued in the same frames, do not disturb one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock, two beats per command cycle |
| rst | input | 1 | Synchronous active-high reset |
| lat_long | input | 1 | Read latency select: 1 = five beats, 0 = two beats |
| rd_sel_n | input | 1 | Active-low read select, sampled on slot 0 |
| wr_sel_n | input | 1 | Active-low write select, sampled on slot 2 |
| addr | input | AW | Shared group address, read on slot 0 and write on slot 2 |
| wdata | input | WORD_W | Write data, one word per beat |
| rd_slot | output | 1 | High when the next edge is a read-address slot |
| rdata | output | WORD_W | Read data, one word per beat |
| rvalid | output | 1 | High on beats that carry read data |

## Verification
The latency properties assume that `lat_long` does not change while any read is between its address edge and its last data beat. The bench changes the mode only after three idle frames. Data comparison assumes that no group is read before it has been written once, so the stimulus fills every group before the first read of each mode. Addresses are assumed to be below the group count, and the stimulus generates them modulo that count. The slot-based properties assume `rst` is held for at least one edge at start-up, which the bench does before any traffic.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int BEATS = 4;

  typedef enum logic [1:0] {
    SL_RD   = 2'd0,
    SL_RD_N = 2'd1,
    SL_WR   = 2'd2,
    SL_WR_N = 2'd3
  } slot_e;

  // Beat on which write word idx (0..2) is staged: one beat after the address.
  function automatic slot_e stage_slot(input int idx);
    return slot_e'(2'((idx + 3) % BEATS));
  endfunction
endpackage

// File: rtl/sbs_slot_gen.sv
module sbs_slot_gen
  import sbs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output slot_e slot
);
  logic [1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= 2'd0;
    else     cnt <= cnt + 2'd1;
  end

  assign slot = slot_e'(cnt);
endmodule

// File: rtl/sbs_write_path.sv
module sbs_write_path
  import sbs_pkg::*;
#(
  parameter int W  = 36,
  parameter int AW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  slot_e                slot,
  input  logic                 wr_sel_n,
  input  logic [AW-1:0]        addr,
  input  logic [W-1:0]         wdata,
  output logic                 wact,
  output logic [AW-1:0]        wgrp,
  output logic [(BEATS-1)*W-1:0] stage,
  output logic                 commit_en,
  output logic [AW-1:0]        commit_grp,
  output logic [BEATS*W-1:0]   commit_data
);
  // Burst bookkeeping: accepted on the write slot, held for four beats.
  always_ff @(posedge clk) begin
    if (rst) begin
      wact <= 1'b0;
      wgrp <= '0;
    end else if (slot == SL_WR) begin
      wact <= ~wr_sel_n;
      if (!wr_sel_n) wgrp <= addr;
    end
  end

  // First three words are staged; the fourth is taken live at commit time.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
    end else begin
      for (int i = 0; i < BEATS - 1; i++) begin
        if (wact && slot == stage_slot(i)) stage[i*W +: W] <= wdata;
      end
    end
  end

  assign commit_en   = wact && (slot == SL_WR);
  assign commit_grp  = wgrp;
  assign commit_data = {wdata, stage};
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int DW    = 144,
  parameter int AW    = 6,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wd;
    rd <= mem[raddr];
  end
endmodule

// File: rtl/sbs_read_path.sv
module sbs_read_path
  import sbs_pkg::*;
#(
  parameter int W  = 36,
  parameter int AW = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  slot_e                  slot,
  input  logic                   rd_sel_n,
  input  logic [AW-1:0]          addr,
  input  logic                   wact,
  input  logic [AW-1:0]          wgrp,
  input  logic [(BEATS-1)*W-1:0] stage,
  input  logic [W-1:0]           wdata,
  input  logic [BEATS*W-1:0]     memq,
  output logic [AW-1:0]          raddr_q,
  output logic                   str_v,
  output logic [W-1:0]           str_d
);
  logic               rd_pend, rd_pend2, fwd, rbuf_v;
  logic [BEATS*W-1:0] rbuf, merged;

  // Merge array data with the write burst that is still being collected.
  always_comb begin
    for (int j = 0; j < BEATS - 1; j++) begin
      merged[j*W +: W] = fwd ? stage[j*W +: W] : memq[j*W +: W];
    end
    merged[(BEATS-1)*W +: W] = fwd ? wdata : memq[(BEATS-1)*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend  <= 1'b0;
      rd_pend2 <= 1'b0;
      fwd      <= 1'b0;
      rbuf_v   <= 1'b0;
      raddr_q  <= '0;
      rbuf     <= '0;
    end else begin
      unique case (slot)
        SL_RD: begin
          rd_pend <= ~rd_sel_n;
          if (!rd_sel_n) raddr_q <= addr;
        end
        SL_RD_N: begin
          rd_pend2 <= rd_pend;
          fwd      <= rd_pend && wact && (wgrp == raddr_q);
        end
        SL_WR: begin
          rbuf_v <= rd_pend2;
          if (rd_pend2) rbuf <= merged;
        end
        default: ;
      endcase
    end
  end

  // Short-latency stream: word 0 straight from the merge, then the snapshot.
  always_comb begin
    unique case (slot)
      SL_WR:   begin str_v = rd_pend2; str_d = merged[0 +: W];   end
      SL_WR_N: begin str_v = rbuf_v;   str_d = rbuf[W +: W];     end
      SL_RD:   begin str_v = rbuf_v;   str_d = rbuf[2*W +: W];   end
      default: begin str_v = rbuf_v;   str_d = rbuf[3*W +: W];   end
    endcase
    if (!str_v) str_d = '0;
  end
endmodule

// File: rtl/sbs_lat_line.sv
module sbs_lat_line #(
  parameter int W     = 36,
  parameter int XTRA  = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lat_long,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  logic         dv [XTRA];
  logic [W-1:0] dd [XTRA];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < XTRA; i++) begin
        dv[i] <= 1'b0;
        dd[i] <= '0;
      end
      out_v <= 1'b0;
      out_d <= '0;
    end else begin
      dv[0] <= in_v;
      dd[0] <= in_d;
      for (int i = 1; i < XTRA; i++) begin
        dv[i] <= dv[i-1];
        dd[i] <= dd[i-1];
      end
      out_v <= lat_long ? dv[XTRA-1] : in_v;
      out_d <= lat_long ? dd[XTRA-1] : in_d;
    end
  end
endmodule

// File: rtl/split_burst_sram.sv
module split_burst_sram
  import sbs_pkg::*;
#(
  parameter  int WORD_W = 36,
  parameter  int GROUPS = 64,
  localparam int AW     = $clog2(GROUPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lat_long,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic              rd_slot,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);
  localparam int GW    = BEATS * WORD_W;
  localparam int LONG_EXTRA = 3;

  slot_e                      slot;
  logic                       wact, commit_en, str_v;
  logic [AW-1:0]              wgrp, commit_grp, raddr_q;
  logic [(BEATS-1)*WORD_W-1:0] stage;
  logic [GW-1:0]              commit_data, memq;
  logic [WORD_W-1:0]          str_d;

  sbs_slot_gen u_slot (.clk(clk), .rst(rst), .slot(slot));

  sbs_write_path #(.W(WORD_W), .AW(AW)) u_wr (
    .clk(clk), .rst(rst), .slot(slot), .wr_sel_n(wr_sel_n), .addr(addr),
    .wdata(wdata), .wact(wact), .wgrp(wgrp), .stage(stage),
    .commit_en(commit_en), .commit_grp(commit_grp), .commit_data(commit_data)
  );

  sbs_array #(.DW(GW), .AW(AW), .DEPTH(GROUPS)) u_mem (
    .clk(clk), .we(commit_en), .waddr(commit_grp), .wd(commit_data),
    .raddr(raddr_q), .rd(memq)
  );

  sbs_read_path #(.W(WORD_W), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .slot(slot), .rd_sel_n(rd_sel_n), .addr(addr),
    .wact(wact), .wgrp(wgrp), .stage(stage), .wdata(wdata), .memq(memq),
    .raddr_q(raddr_q), .str_v(str_v), .str_d(str_d)
  );

  sbs_lat_line #(.W(WORD_W), .XTRA(LONG_EXTRA)) u_lat (
    .clk(clk), .rst(rst), .lat_long(lat_long), .in_v(str_v), .in_d(str_d),
    .out_v(rvalid), .out_d(rdata)
  );

  assign rd_slot = (slot == SL_RD);
endmodule

// File: rtl/split_burst_sram_chk.sv
module split_burst_sram_chk #(
  parameter int WORD_W = 36,
  parameter int AW     = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              lat_long,
  input logic              rd_sel_n,
  input logic              wr_sel_n,
  input logic [AW-1:0]     addr,
  input logic [WORD_W-1:0] wdata,
  input logic              rd_slot,
  input logic [WORD_W-1:0] rdata,
  input logic              rvalid
);
  p_reset_slot_r1: assert property (@(posedge clk)
    $fell(rst) |-> (rd_slot && !rvalid));

  p_slot_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    rd_slot |=> !rd_slot ##1 !rd_slot ##1 !rd_slot ##1 rd_slot);

  p_short_lat_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_slot && !rd_sel_n && !lat_long) |-> ##3 rvalid);

  p_long_lat_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_slot && !rd_sel_n && lat_long) |-> ##6 rvalid);

  p_burst_len_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) |=> rvalid ##1 rvalid ##1 rvalid);

  p_desel_short_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_slot && rd_sel_n && !lat_long) |-> ##3 !rvalid);

  p_desel_long_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_slot && rd_sel_n && lat_long) |-> ##6 !rvalid);

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == '0));
endmodule

bind split_burst_sram split_burst_sram_chk #(.WORD_W(WORD_W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .lat_long(lat_long), .rd_sel_n(rd_sel_n),
  .wr_sel_n(wr_sel_n), .addr(addr), .wdata(wdata), .rd_slot(rd_slot),
  .rdata(rdata), .rvalid(rvalid)
);

// File: tb/tb_split_burst_sram.sv
module tb_split_burst_sram;
  localparam int WW = 16;
  localparam int G  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lat_long = 1'b0;
  logic          rd_sel_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wdata = '0;
  logic          rd_slot, rvalid;
  logic [WW-1:0] rdata;

  split_burst_sram #(.WORD_W(WW), .GROUPS(G)) dut (
    .clk(clk), .rst(rst), .lat_long(lat_long), .rd_sel_n(rd_sel_n),
    .wr_sel_n(wr_sel_n), .addr(addr), .wdata(wdata), .rd_slot(rd_slot),
    .rdata(rdata), .rvalid(rvalid)
  );

  always #10 clk = ~clk;

  int            n_chk = 0, n_fail = 0;
  int            e = 0;
  int            seq = 0;
  logic [WW-1:0] refm [G][4];
  logic          exp_v [16];
  logic [WW-1:0] exp_d [16];
  string         exp_tag [16];
  logic [WW-1:0] wcur [4];
  logic          wcur_act = 1'b0;

  function automatic logic [WW-1:0] wf(input int sq, input int g, input int j);
    return WW'(sq * 1031 + g * 97 + j * 13 + 5);
  endfunction

  function automatic logic [WW-1:0] junk(input int k);
    return WW'(16'hBEEF ^ (k * 4099));
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s edge=%0d actual=%h expected=%h", tag, what, e, act, expv);
    end
  endtask

  // One beat: edge, then sample at the falling edge.
  task automatic step();
    int idx;
    @(posedge clk);
    @(negedge clk);
    idx = e % 16;
    chk(rvalid == exp_v[idx], {lat_long ? "R5 R6 " : "R4 R6 ", exp_tag[idx]},
        "rvalid", 32'(rvalid), 32'(exp_v[idx]));
    if (exp_v[idx])
      chk(rdata == exp_d[idx], exp_tag[idx], "rdata", 32'(rdata), 32'(exp_d[idx]));
    else
      chk(rdata == '0, "R10", "idle rdata", 32'(rdata), 32'd0);
    exp_v[idx] = 1'b0;
    exp_tag[idx] = "R6";
    e++;
    chk(rd_slot == (e % 4 == 0), "R2", "rd_slot", 32'(rd_slot), 32'(e % 4 == 0));
  endtask

  // One command frame: read slot, then write slot two beats later.
  task automatic frame(input bit re, input int rg, input bit we, input int wg,
                       input string tg);
    int lat;
    for (int s = 0; s < 4; s++) begin
      rd_sel_n = 1'b0;
      wr_sel_n = 1'b0;
      addr     = AW'((e * 3 + 1) % G);
      case (s)
        0: begin
          rd_sel_n = ~re;
          addr     = AW'(rg);
          wdata    = wcur_act ? wcur[1] : junk(e);
          lat      = lat_long ? 5 : 2;
          for (int j = 0; j < 4; j++) begin
            exp_v[(e + lat + j) % 16]   = re;
            exp_d[(e + lat + j) % 16]   = refm[rg][j];
            exp_tag[(e + lat + j) % 16] = re ? tg : "R7";
          end
        end
        1: wdata = wcur_act ? wcur[2] : junk(e);
        2: begin
          wdata    = wcur_act ? wcur[3] : junk(e);
          wr_sel_n = ~we;
          addr     = AW'(wg);
          if (we) begin
            seq++;
            for (int j = 0; j < 4; j++) begin
              wcur[j]     = wf(seq, wg, j);
              refm[wg][j] = wcur[j];
            end
          end
          wcur_act = we;
        end
        default: wdata = wcur_act ? wcur[0] : junk(e);
      endcase
      step();
    end
  endtask

  task automatic run_mode();
    for (int g = 0; g < G; g++) frame(0, 0, 1, g, "R3");
    frame(0, 0, 0, 0, "R6");
    for (int g = 0; g < G; g++) frame(1, g, 0, 0, "R3");
    for (int k = 0; k < 8; k++) frame(1, (k * 5) % G, 0, 0, "R9");
    for (int k = 0; k < 256; k++)
      frame((k % 7) != 3, k % G, (k % 5) != 2, (k * 7 + 3) % G, "R11");
    // Write then read the same group in the following frame.
    for (int k = 0; k <= G; k++) frame(k > 0, (k + G - 1) % G, k < G, k % G, "R8");
    // Read then write the same group in the same frame: old data expected.
    for (int g = 0; g < G; g++) frame(1, g, 1, g, "R8");
    // Deselected write must leave the group unchanged.
    frame(0, 0, 1, 5, "R7");
    frame(0, 0, 0, 5, "R7");
    frame(1, 5, 0, 0, "R7");
    for (int k = 0; k < 3; k++) frame(0, 0, 0, 0, "R6");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      exp_v[i] = 1'b0;
      exp_d[i] = '0;
      exp_tag[i] = "R6";
    end
    for (int g = 0; g < G; g++)
      for (int j = 0; j < 4; j++) refm[g][j] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rvalid == 1'b0, "R1", "reset rvalid", 32'(rvalid), 32'd0);
    chk(rdata == '0, "R1", "reset rdata", 32'(rdata), 32'd0);
    chk(rd_slot == 1'b1, "R1", "reset rd_slot", 32'(rd_slot), 32'd1);
    rst = 1'b0;
    lat_long = 1'b0;
    run_mode();
    lat_long = 1'b1;
    run_mode();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired edge=%0d actual=hung expected=done", e);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule